// File: doc/BRIEF.md
# Lockable Device Control Register Bank

This block is a word-addressed register bank on a simple CPU bus. A transfer is one cycle of `sel`, with `we` marking a write, an 8-bit word address and a 32-bit write word. The bank answers every selected cycle: one cycle later it raises `ready` for one cycle and drives `rdata`. The bus has no back-pressure. The bank always accepts a transfer and never stalls, so `ready` is a response strobe and not a handshake. The address map is fixed, because boot code decodes it.

The bank holds three read-only identity words, a set of LED controls, and a four-bit GPIO port. Two bits of that port are synchronised inputs and two are driven outputs. Boot software also writes a group of privileged values here: a load base, a load length, a routine pointer and an eight-word (256-bit) secret. A mode bit that can be set only once moves the system from firmware mode to application mode. From that point the privileged group is frozen until reset, but it stays readable. The `fw_priv` input marks a transfer as coming from firmware. The system is expected to drive it as the inverse of `app_mode`.

Top module: `devctl_regs`

## Requirements
- R1: Word addresses 0x00 and 0x01 read 32'h6465_7663 and 32'h746c_7231, and 0x02 reads 32'h0000_0003. All three are readable in both modes, and writes to them change nothing.
- R2: A write to 0x08 sets `app_mode` only when `fw_priv` is 1, `app_mode` is 0 and write-data bit 0 is 1. Once set, `app_mode` stays at 1 until reset. Address 0x08 reads the mode in bit 0.
- R3: Address 0x09 holds the LED controls in bits 2:0 (bit 0 blue, bit 1 green, bit 2 red). A 1 lights the colour on `led[2:0]` one cycle after the write. The register can be read and written in both modes.
- R4: Address 0x0a reads the synchronised `gpio_in` in bits 1:0 and the stored outputs in bits 3:2. Writes change only bits 3:2, which drive `gpio_out[1:0]`. A level that `gpio_in` holds before clock edge k appears in read data captured at edge k+2 or later.
- R5: Addresses 0x0c (load base) and 0x0d (load length) are readable at all times. They are writable only by a privileged write.
- R6: Address 0x10 holds a 32-bit routine pointer that is readable at all times and writable only by a privileged write.
- R7: Addresses 0x20 to 0x27 hold the eight words of a 256-bit secret, word 0 at 0x20. They are readable at all times and writable only by a privileged write.
- R8: Reads of any address not listed in R1 to R7 return zero. Writes to such addresses have no effect.
- R9: Reset clears every stored register, `app_mode`, `led`, `gpio_out`, `ready` and `rdata` to zero.
- R10: A selected cycle at edge k produces `ready` = 1 and `rdata` = the addressed value before edge k+1. For a write, `rdata` holds the value from before the write. `ready` is 0 in any cycle that did not follow a select.
- R11: A privileged write is one with `fw_priv` = 1 while `app_mode` = 0. Writes that fail this test are dropped silently, including a write that would set the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Transfer select |
| we | input | 1 | Write when 1, read when 0 |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| fw_priv | input | 1 | Transfer issued by firmware |
| gpio_in | input | 2 | Asynchronous GPIO input pins |
| rdata | output | 32 | Read data, valid with ready |
| ready | output | 1 | One-cycle response strobe |
| app_mode | output | 1 | Application mode flag |
| led | output | 3 | LED enables: blue, green, red |
| gpio_out | output | 2 | GPIO output pins |

## Verification
Every bus result registers once. `ready`, `rdata`, `led`, `gpio_out` and `app_mode` all change at the first edge after the selected cycle. A GPIO input level needs two more edges before a read can capture it. The bench drives stimulus on falling edges. It advances a behavioural model on each rising edge, taking the read value before it applies the write, and it compares all outputs on the next falling edge. Because every check falls in the cycle in which the result is due, a result that arrives a cycle early or a cycle late shows up as a mismatch.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_ID0     = 8'h00;
  localparam logic [ADDR_W-1:0] A_ID1     = 8'h01;
  localparam logic [ADDR_W-1:0] A_REV     = 8'h02;
  localparam logic [ADDR_W-1:0] A_MODE    = 8'h08;
  localparam logic [ADDR_W-1:0] A_LED     = 8'h09;
  localparam logic [ADDR_W-1:0] A_GPIO    = 8'h0a;
  localparam logic [ADDR_W-1:0] A_LDBASE  = 8'h0c;
  localparam logic [ADDR_W-1:0] A_LDLEN   = 8'h0d;
  localparam logic [ADDR_W-1:0] A_RTNPTR  = 8'h10;
  localparam logic [ADDR_W-1:0] A_KEY0    = 8'h20;
endpackage

// File: rtl/devctl_sync.sv
module devctl_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/devctl_lockbank.sv
module devctl_lockbank
  import devctl_pkg::*;
#(
  parameter int KEY_WORDS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_ok,
  input  logic                             locked,
  input  logic [ADDR_W-1:0]                waddr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                base_q,
  output logic [DATA_W-1:0]                len_q,
  output logic [DATA_W-1:0]                ptr_q,
  output logic [KEY_WORDS-1:0][DATA_W-1:0] key_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      ptr_q  <= '0;
    end else if (wr_ok) begin
      if (waddr == A_LDBASE) base_q <= wdata;
      if (waddr == A_LDLEN)  len_q  <= wdata;
      if (waddr == A_RTNPTR) ptr_q  <= wdata;
    end
  end

  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    localparam logic [ADDR_W-1:0] KADDR = A_KEY0 + ADDR_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        key_q[i] <= '0;
      else if (wr_ok && waddr == KADDR)  key_q[i] <= wdata;
    end
  end

  AST_FROZEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(base_q) && $stable(len_q))); // R5
  AST_FROZEN_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ptr_q)); // R6
  AST_FROZEN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(key_q)); // R7
endmodule

// File: rtl/devctl_rdmux.sv
module devctl_rdmux
  import devctl_pkg::*;
#(
  parameter int          KEY_WORDS = 8,
  parameter logic [31:0] ID_WORD0  = 32'h6465_7663,
  parameter logic [31:0] ID_WORD1  = 32'h746c_7231,
  parameter logic [31:0] REV_WORD  = 32'h0000_0003
) (
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             mode,
  input  logic [2:0]                       led,
  input  logic [3:0]                       gpio_word,
  input  logic [DATA_W-1:0]                base,
  input  logic [DATA_W-1:0]                len,
  input  logic [DATA_W-1:0]                ptr,
  input  logic [KEY_WORDS-1:0][DATA_W-1:0] key,
  output logic [DATA_W-1:0]                word
);
  localparam int KIDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;

  logic [ADDR_W-1:0] koff;
  assign koff = addr - A_KEY0;

  always_comb begin
    word = '0;
    if (koff < ADDR_W'(KEY_WORDS)) begin
      word = key[koff[KIDX_W-1:0]];
    end else begin
      case (addr)
        A_ID0:    word = ID_WORD0;
        A_ID1:    word = ID_WORD1;
        A_REV:    word = REV_WORD;
        A_MODE:   word = {{(DATA_W-1){1'b0}}, mode};
        A_LED:    word = {{(DATA_W-3){1'b0}}, led};
        A_GPIO:   word = {{(DATA_W-4){1'b0}}, gpio_word};
        A_LDBASE: word = base;
        A_LDLEN:  word = len;
        A_RTNPTR: word = ptr;
        default:  word = '0;
      endcase
    end
  end
endmodule

// File: rtl/devctl_regs.sv
module devctl_regs
  import devctl_pkg::*;
#(
  parameter int KEY_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fw_priv,
  input  logic [1:0]        gpio_in,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              app_mode,
  output logic [2:0]        led,
  output logic [1:0]        gpio_out
);
  logic                             mode_q;
  logic [2:0]                       led_q;
  logic [1:0]                       gout_q;
  logic [1:0]                       gin_sync;
  logic [DATA_W-1:0]                rdata_q, rd_word;
  logic                             ready_q;
  logic                             wr_any, wr_priv;
  logic [DATA_W-1:0]                base_w, len_w, ptr_w;
  logic [KEY_WORDS-1:0][DATA_W-1:0] key_w;

  assign wr_any  = sel && we;
  assign wr_priv = wr_any && fw_priv && !mode_q;

  devctl_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gin_sync)
  );

  devctl_lockbank #(.KEY_WORDS(KEY_WORDS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_priv), .locked(mode_q),
    .waddr(addr), .wdata(wdata),
    .base_q(base_w), .len_q(len_w), .ptr_q(ptr_w), .key_q(key_w)
  );

  devctl_rdmux #(.KEY_WORDS(KEY_WORDS)) u_rdmux (
    .addr(addr), .mode(mode_q), .led(led_q), .gpio_word({gout_q, gin_sync}),
    .base(base_w), .len(len_w), .ptr(ptr_w), .key(key_w), .word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      led_q   <= '0;
      gout_q  <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= sel;
      if (sel) rdata_q <= rd_word;
      if (wr_priv && addr == A_MODE && wdata[0]) mode_q <= 1'b1;
      if (wr_any && addr == A_LED)  led_q  <= wdata[2:0];
      if (wr_any && addr == A_GPIO) gout_q <= wdata[3:2];
    end
  end

  assign rdata    = rdata_q;
  assign ready    = ready_q;
  assign app_mode = mode_q;
  assign led      = led_q;
  assign gpio_out = gout_q;

  AST_READY_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> ready); // R10
  AST_READY_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !ready); // R10
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode |=> app_mode); // R2
  AST_MODE_NEEDS_FW: assert property (@(posedge clk) disable iff (!rst_n)
    (!app_mode && !fw_priv) |=> !app_mode); // R11
  AST_LED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && addr == A_LED) |=> (led == $past(wdata[2:0]))); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && addr >= 8'h40) |=> (rdata == '0)); // R8
endmodule

// File: tb/devctl_regs_test.sv
module devctl_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID0 = 32'h6465_7663;
  localparam logic [31:0] ID1 = 32'h746c_7231;
  localparam logic [31:0] REV = 32'h0000_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0, fw_priv = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  gpio_in = '0;
  logic [31:0] rdata;
  logic        ready, app_mode;
  logic [2:0]  led;
  logic [1:0]  gpio_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  devctl_regs uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .fw_priv(fw_priv), .gpio_in(gpio_in), .rdata(rdata), .ready(ready),
    .app_mode(app_mode), .led(led), .gpio_out(gpio_out)
  );

  // behavioural reference model
  logic [31:0] m_store [0:255];
  logic        m_mode, m_ready;
  logic [2:0]  m_led;
  logic [1:0]  m_gout, m_s1, m_s2;
  logic [31:0] m_rdata;
  string       m_tag = "R9";

  function automatic bit is_priv_addr(input logic [7:0] a);
    return (a == 8'h0c) || (a == 8'h0d) || (a == 8'h10) || (a >= 8'h20 && a <= 8'h27);
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a <= 8'h02) return "R1";
    if (a == 8'h08) return "R2";
    if (a == 8'h09) return "R3";
    if (a == 8'h0a) return "R4";
    if (a == 8'h0c || a == 8'h0d) return "R5";
    if (a == 8'h10) return "R6";
    if (a >= 8'h20 && a <= 8'h27) return "R7";
    return "R8";
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return ID0;
      8'h01: return ID1;
      8'h02: return REV;
      8'h08: return {31'b0, m_mode};
      8'h09: return {29'b0, m_led};
      8'h0a: return {28'b0, m_gout, m_s2};
      default: return is_priv_addr(a) ? m_store[a] : 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_store[i] = '0;
      m_mode = 0; m_ready = 0; m_led = '0; m_gout = '0;
      m_s1 = '0; m_s2 = '0; m_rdata = '0; m_tag = "R9";
    end else begin
      logic priv_ok;
      priv_ok = fw_priv && !m_mode;
      m_ready = sel;
      if (sel) begin
        m_rdata = model_read(addr);
        m_tag = tag_of(addr);
      end
      if (sel && we) begin
        if (addr == 8'h09) m_led = wdata[2:0];
        if (addr == 8'h0a) m_gout = wdata[3:2];
        if (addr == 8'h08 && priv_ok && wdata[0]) m_mode = 1'b1;
        if (is_priv_addr(addr) && priv_ok) m_store[addr] = wdata;
      end
      m_s2 = m_s1;
      m_s1 = gpio_in;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10", "ready", {31'b0, ready}, {31'b0, m_ready});
      check(m_tag, "rdata", rdata, m_rdata);
      check("R2", "app_mode", {31'b0, app_mode}, {31'b0, m_mode});
      check("R3", "led", {29'b0, led}, {29'b0, m_led});
      check("R4", "gpio_out", {30'b0, gpio_out}, {30'b0, m_gout});
    end
  end

  task automatic idle();
    sel = 0; we = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic fw);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d; fw_priv = fw;
    @(negedge clk);
    sel = 0; we = 0; fw_priv = !app_mode;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    sel = 1; we = 0; addr = a; fw_priv = !app_mode;
    @(negedge clk);
    sel = 0;
  endtask

  // direct checks of the ready/rdata timing at the ports
  task automatic rd_expect(input string req, input logic [7:0] a, input logic [31:0] exp);
    rd(a);
    check(req, "direct read", rdata, exp);
    check("R10", "ready pulse", {31'b0, ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    check("R9", "rdata after reset", rdata, 32'h0);
    check("R9", "led after reset", {29'b0, led}, 32'h0);
    check("R9", "app_mode after reset", {31'b0, app_mode}, 32'h0);
    rd_expect("R9", 8'h0c, 32'h0);
    rd_expect("R9", 8'h27, 32'h0);
    // R1 identity
    rd_expect("R1", 8'h00, ID0);
    rd_expect("R1", 8'h01, ID1);
    wr(8'h02, 32'hffff_ffff, 1);
    rd_expect("R1", 8'h02, REV);
    // R3 LED patterns
    wr(8'h09, 32'h0000_0001, 1);
    check("R3", "blue on", {29'b0, led}, 32'h1);
    wr(8'h09, 32'hffff_fffc, 1);
    rd_expect("R3", 8'h09, 32'h4);
    wr(8'h09, 32'h0000_0003, 1);
    // R4 GPIO
    gpio_in = 2'b10;
    repeat (3) @(negedge clk);
    wr(8'h0a, 32'h0000_000f, 1);
    rd_expect("R4", 8'h0a, 32'h0000_000e);
    gpio_in = 2'b01;
    wr(8'h0a, 32'h0000_0004, 1);
    repeat (2) @(negedge clk);
    rd_expect("R4", 8'h0a, 32'h0000_0005);
    // R5 R6 R7 privileged writes in firmware mode
    wr(8'h0c, 32'h0001_0000, 1);
    wr(8'h0d, 32'h0000_2400, 1);
    wr(8'h10, 32'h0000_1a2c, 1);
    for (int i = 0; i < 8; i++) wr(8'h20 + 8'(i), 32'hc0de_0000 + 32'(i * 17), 1);
    rd_expect("R5", 8'h0d, 32'h0000_2400);
    rd_expect("R6", 8'h10, 32'h0000_1a2c);
    rd_expect("R7", 8'h27, 32'hc0de_0077);
    // R11 non-firmware writes dropped before the mode is set
    wr(8'h10, 32'hdead_beef, 0);
    wr(8'h08, 32'h1, 0);
    rd_expect("R11", 8'h10, 32'h0000_1a2c);
    check("R11", "mode not set", {31'b0, app_mode}, 32'h0);
    // R2 mode switch
    wr(8'h08, 32'h0, 1);
    check("R2", "zero write keeps fw mode", {31'b0, app_mode}, 32'h0);
    wr(8'h08, 32'h1, 1);
    check("R2", "mode set", {31'b0, app_mode}, 32'h1);
    rd_expect("R2", 8'h08, 32'h1);
    wr(8'h08, 32'h0, 1);
    check("R2", "mode sticky", {31'b0, app_mode}, 32'h1);
    // locked group ignores writes even with fw_priv forced
    wr(8'h0c, 32'h1234_5678, 1);
    wr(8'h10, 32'h1111_1111, 1);
    wr(8'h23, 32'h2222_2222, 1);
    rd_expect("R5", 8'h0c, 32'h0001_0000);
    rd_expect("R6", 8'h10, 32'h0000_1a2c);
    rd_expect("R7", 8'h23, 32'hc0de_0033);
    rd_expect("R1", 8'h00, ID0);
    // LED still writable in application mode
    wr(8'h09, 32'h5, 0);
    rd_expect("R3", 8'h09, 32'h5);
    // R8 unmapped
    wr(8'h03, 32'hffff_ffff, 0);
    rd_expect("R8", 8'h03, 32'h0);
    rd_expect("R8", 8'h0b, 32'h0);
    rd_expect("R8", 8'h28, 32'h0);
    rd_expect("R8", 8'hff, 32'h0);
    // R10 back-to-back reads and a write returning old data
    @(negedge clk);
    sel = 1; we = 0; addr = 8'h01;
    @(negedge clk);
    check("R10", "first of pair", rdata, ID1);
    addr = 8'h20;
    @(negedge clk);
    check("R10", "second of pair", rdata, 32'hc0de_0000);
    we = 1; addr = 8'h09; wdata = 32'h2;
    @(negedge clk);
    check("R10", "write returns old", rdata, 32'h5);
    sel = 0; we = 0;
    @(negedge clk);
    check("R10", "ready drops", {31'b0, ready}, 32'h0);
    // R9 reset mid-run clears the mode
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9", "mode cleared", {31'b0, app_mode}, 32'h0);
    rd_expect("R9", 8'h10, 32'h0);
    idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule